// File: doc/BRIEF.md
# Two-Level Interval PWM Generator

This block generates a pulse-width-modulated output. The timebase is a short interval of 256 count-source ticks. Four short intervals form one long interval. An 8-bit coarse setting gives the number of ticks the output is high in each short interval. A 2-bit fine setting adds one more high tick to that many of the four short intervals. Across one long interval the duty resolution is therefore one tick in 1024. A one-clock interrupt pulse marks the start of every long interval.

Software writes land in shadow registers. The shadow values become active only when a long interval begins or when output starts from a stop, so a duty change never leaves a long interval partly old and partly new.

When `run` drops, the counters freeze and the output holds its level. The level at the stop decides how the next start behaves. After a high stop, output resumes at once. After a low stop, the output stays low for one extra short interval before the first long interval begins.

Top module: `dual_interval_pwm`

## Requirements
- R1: During and right after synchronous reset, `pwm_out` and `irq` are 0 and the block is stopped.
- R2: While running with `cnt_en` high every clock, `irq` is a one-clock pulse, and successive pulses are exactly 1024 clocks apart (4 short intervals of 256 ticks). Section 0 starts on the clock in which `irq` is high.
- R3: In section k of a long interval, `pwm_out` is high for the first H+e ticks. H is the coarse setting and e is 1 for the sections selected by R4, otherwise 0. Over a long interval the high time is 4H+F. When H=255 and e=1, the whole short interval is high.
- R4: The fine value F is taken from `wr_data[1:0]`. Bits 7:2 of a fine write are ignored. F=1 adds the extra tick to section 0. F=2 adds it to sections 0 and 2. F=3 adds it to sections 0, 1 and 2.
- R5: With H=0 and F=0 active, `pwm_out` stays low for the whole long interval.
- R6: A write with `wr_en`=1 stores `wr_data` into the coarse shadow (`wr_sel`=0) or the fine shadow (`wr_sel`=1). The active settings change only at a long-interval start or at a start from stop. A write in the middle of a long interval does not change that interval.
- R7: Phase advances only on clocks with `cnt_en`=1. With `cnt_en` high every other clock, the interrupt period and the high time both double.
- R8: While `run` is 0, the counters hold, no `irq` occurs, and `pwm_out` keeps the level it had when `run` fell.
- R9: After a stop with `pwm_out` high, raising `run` starts section 0 on the next clock. The first `irq` comes 1025 clocks after `run` is first sampled high.
- R10: After a stop with `pwm_out` low, raising `run` first holds `pwm_out` low for 256 ticks. The output goes high 257 clocks after `run` is first sampled high (with H>0), and the first `irq` comes at 1281 clocks.
- R11: The first start after reset behaves like R9. The output goes high on the first clock when H>0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-source tick enable |
| run | input | 1 | 1 = output running, 0 = stopped |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 1 | 0 = coarse shadow, 1 = fine shadow |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | One-clock pulse at each long-interval start |

## Verification
A wrong phase or section counter shows up within one long interval, as a shifted `irq` spacing or a wrong per-section high count. A corrupted active setting changes the measured high time of the very next long interval. A wrong stop-level flag moves the restart latency by exactly 256 clocks, which the bench sees on the first output edge after `run` rises.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int PHASE_W  = 8;
    localparam int SECT_W   = 2;
    localparam int COARSE_W = PHASE_W;
    localparam int FINE_W   = SECT_W;
    localparam int WIDTH_W  = PHASE_W + 1;

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [SECT_W-1:0]  sect_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } setting_t;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

    // Reverse the section index so that the extra ticks are spread out.
    function automatic sect_t bit_rev(sect_t s);
        sect_t r;
        for (int i = 0; i < SECT_W; i++) begin
            r[i] = s[SECT_W-1-i];
        end
        return r;
    endfunction

    function automatic logic extra_hit(sect_t s, logic [FINE_W-1:0] f);
        return bit_rev(s) < f;
    endfunction

    function automatic logic [WIDTH_W-1:0] high_width(setting_t st, sect_t s);
        return WIDTH_W'(st.coarse) + WIDTH_W'(extra_hit(s, st.fine));
    endfunction

endpackage

// File: rtl/pwm2_shadow.sv
module pwm2_shadow
    import pwm2_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [COARSE_W-1:0] wr_data,
    output setting_t            shadow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                shadow.fine <= wr_data[FINE_W-1:0];
            end else begin
                shadow.coarse <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm2_sequencer.sv
module pwm2_sequencer
    import pwm2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   run,
    input  logic   out_level,
    output mode_e  mode_q,
    output mode_e  mode_d,
    output phase_t phase_q,
    output phase_t phase_d,
    output sect_t  sect_q,
    output sect_t  sect_d,
    output logic   load_d,
    output logic   irq_q
);

    localparam phase_t PHASE_LAST = '1;
    localparam sect_t  SECT_LAST  = '1;

    logic low_stop_q, low_stop_d;
    logic boundary;

    always_comb begin
        mode_d     = mode_q;
        phase_d    = phase_q;
        sect_d     = sect_q;
        load_d     = 1'b0;
        boundary   = 1'b0;
        low_stop_d = low_stop_q;
        unique case (mode_q)
            MODE_IDLE: begin
                if (run) begin
                    phase_d = '0;
                    sect_d  = '0;
                    if (low_stop_q) begin
                        mode_d = MODE_HOLD;
                    end else begin
                        mode_d = MODE_RUN;
                        load_d = 1'b1;
                    end
                end
            end
            MODE_HOLD: begin
                if (!run) begin
                    mode_d = MODE_IDLE;
                end else if (tick) begin
                    if (phase_q == PHASE_LAST) begin
                        phase_d    = '0;
                        mode_d     = MODE_RUN;
                        load_d     = 1'b1;
                        low_stop_d = 1'b0;
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
            end
            MODE_RUN: begin
                if (!run) begin
                    mode_d     = MODE_IDLE;
                    low_stop_d = !out_level;
                end else if (tick) begin
                    if (phase_q == PHASE_LAST) begin
                        phase_d = '0;
                        if (sect_q == SECT_LAST) begin
                            sect_d   = '0;
                            load_d   = 1'b1;
                            boundary = 1'b1;
                        end else begin
                            sect_d = sect_q + 1'b1;
                        end
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
            end
            default: mode_d = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_IDLE;
            phase_q    <= '0;
            sect_q     <= '0;
            low_stop_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            phase_q    <= phase_d;
            sect_q     <= sect_d;
            low_stop_q <= low_stop_d;
            irq_q      <= boundary;
        end
    end

endmodule

// File: rtl/pwm2_shaper.sv
module pwm2_shaper
    import pwm2_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_e    mode_d,
    input  phase_t   phase_d,
    input  sect_t    sect_d,
    input  logic     load_d,
    input  setting_t shadow,
    output setting_t active_q,
    output logic     pwm_q
);

    setting_t            active_d;
    logic [WIDTH_W-1:0]  width_d;
    logic                level_d;

    always_comb begin
        active_d = load_d ? shadow : active_q;
        width_d  = high_width(active_d, sect_d);
        unique case (mode_d)
            MODE_RUN:  level_d = {1'b0, phase_d} < width_d;
            MODE_HOLD: level_d = 1'b0;
            default:   level_d = pwm_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            pwm_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            pwm_q    <= level_d;
        end
    end

endmodule

// File: rtl/dual_interval_pwm.sv
module dual_interval_pwm
    import pwm2_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic                run,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [COARSE_W-1:0] wr_data,
    output logic                pwm_out,
    output logic                irq
);

    setting_t shadow;
    setting_t active_q;
    mode_e    mode_q, mode_d;
    phase_t   phase_q, phase_d;
    sect_t    sect_q, sect_d;
    logic     load_d;

    pwm2_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .shadow  (shadow)
    );

    pwm2_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (cnt_en),
        .run       (run),
        .out_level (pwm_out),
        .mode_q    (mode_q),
        .mode_d    (mode_d),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .sect_q    (sect_q),
        .sect_d    (sect_d),
        .load_d    (load_d),
        .irq_q     (irq)
    );

    pwm2_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .mode_d   (mode_d),
        .phase_d  (phase_d),
        .sect_d   (sect_d),
        .load_d   (load_d),
        .shadow   (shadow),
        .active_q (active_q),
        .pwm_q    (pwm_out)
    );

endmodule

// File: rtl/dual_interval_pwm_chk.sv
module dual_interval_pwm_chk
    import pwm2_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     cnt_en,
    input logic     run,
    input logic     pwm_out,
    input logic     irq,
    input mode_e    mode_q,
    input phase_t   phase_q,
    input sect_t    sect_q,
    input setting_t active
);

    localparam phase_t PH_END = '1;
    localparam sect_t  SC_END = '1;

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mode_q == MODE_RUN && phase_q == '0 && sect_q == '0));

    assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && active.coarse == '0 && active.fine == '0) |-> !pwm_out);

    assert_active_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && run && !(cnt_en && phase_q == PH_END && sect_q == SC_END))
        |=> $stable(active));

    assert_tick_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && run && !cnt_en) |=> ($stable(phase_q) && $stable(sect_q)));

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDLE && !run) |=> ($stable(pwm_out) && !irq));

    assert_hold_low_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HOLD) |-> !pwm_out);

endmodule

bind dual_interval_pwm dual_interval_pwm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .run     (run),
    .pwm_out (pwm_out),
    .irq     (irq),
    .mode_q  (mode_q),
    .phase_q (phase_q),
    .sect_q  (sect_q),
    .active  (active_q)
);

// File: tb/test_dual_interval_pwm.sv
`timescale 1ns/1ps
module test_dual_interval_pwm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b1;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       slow = 1'b0;
    wire        pwm_out;
    wire        irq;

    int checks = 0;
    int errs = 0;
    int m_len, m_high;
    int m_sec[4];
    int l_hi, l_irq;

    // {coarse, fine write byte, expected high ticks per long interval}
    localparam logic [26:0] VEC [7] = '{
        {8'd0,   8'h00, 11'd0},
        {8'd1,   8'h00, 11'd4},
        {8'd128, 8'h02, 11'd514},
        {8'd255, 8'h03, 11'd1023},
        {8'd255, 8'h00, 11'd1020},
        {8'd10,  8'hFD, 11'd41},
        {8'd0,   8'h03, 11'd3}
    };

    dual_interval_pwm i_dual_interval_pwm (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .run     (run),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            cnt_en = slow ? ~cnt_en : 1'b1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sec(int h, int f, int k);
        int e;
        e = ((f == 1 && k == 0) || (f == 2 && (k == 0 || k == 2)) || (f == 3 && k != 3)) ? 1 : 0;
        return h + e;
    endfunction

    task automatic wr(bit sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (irq !== 1'b1);
    endtask

    // Starts on a negedge where irq is high; ends on the next such negedge.
    task automatic measure(bit do_wr, logic [7:0] wh, logic [7:0] wf);
        m_len = 0; m_high = 0;
        for (int k = 0; k < 4; k++) m_sec[k] = 0;
        do begin
            if (pwm_out) begin
                m_high++;
                if (m_len < 1024) m_sec[m_len / 256]++;
            end
            if (do_wr && m_len == 300) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = wh; end
            if (do_wr && m_len == 301) begin wr_sel = 1'b1; wr_data = wf; end
            if (do_wr && m_len == 302) wr_en = 1'b0;
            @(negedge clk);
            m_len++;
        end while (irq !== 1'b1 && m_len < 5000);
    endtask

    // Raise run and record clocks to first high output and to first irq.
    task automatic start_latency();
        l_hi = -1; l_irq = -1;
        run = 1'b1;
        for (int n = 1; n < 3000; n++) begin
            @(negedge clk);
            if (pwm_out && l_hi < 0) l_hi = n;
            if (irq) begin l_irq = n; break; end
        end
    endtask

    initial begin
        int bad_irq, bad_lvl;
        repeat (5) @(negedge clk);
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        chk("R1 irq in reset", int'(irq), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 pwm_out stopped after reset", int'(pwm_out), 0);

        // First start after reset
        wr(1'b0, 8'd100);
        wr(1'b1, 8'h00);
        start_latency();
        chk("R11 first high after start", l_hi, 1);
        chk("R11 first irq after start", l_irq, 1025);

        // Vector table
        for (int v = 0; v < 7; v++) begin
            int h, f;
            h = int'(VEC[v][26:19]);
            f = int'(VEC[v][12:11]);
            wr(1'b0, VEC[v][26:19]);
            wr(1'b1, VEC[v][18:11]);
            wait_irq();
            measure(1'b0, 8'd0, 8'd0);
            chk("R2 long interval length", m_len, 1024);
            chk("R3 long interval high total", m_high, int'(VEC[v][10:0]));
            for (int k = 0; k < 4; k++)
                chk("R4 section high count", m_sec[k], exp_sec(h, f, k));
        end

        // Write mid interval: old settings (0,3) stay for this interval
        measure(1'b1, 8'd40, 8'd0);
        chk("R6 mid-interval write not applied", m_high, 3);
        measure(1'b0, 8'd0, 8'd0);
        chk("R6 write applied at next boundary", m_high, 160);
        chk("R5 zero setting section 3 low", m_sec[3] - 40, 0);

        // Slow count source
        wr(1'b0, 8'd64);
        wr(1'b1, 8'h01);
        wait_irq();
        slow = 1'b1;
        wait_irq();
        measure(1'b0, 8'd0, 8'd0);
        chk("R7 slow interval length", m_len, 2048);
        chk("R7 slow high total", m_high, 514);
        slow = 1'b0;
        wait_irq();

        // Stop while high
        wr(1'b0, 8'd100);
        wr(1'b1, 8'h00);
        wait_irq();
        repeat (10) @(negedge clk);
        chk("R3 output high early in section", int'(pwm_out), 1);
        run = 1'b0;
        bad_irq = 0; bad_lvl = 0;
        repeat (1100) begin
            @(negedge clk);
            if (irq) bad_irq++;
            if (pwm_out !== 1'b1) bad_lvl++;
        end
        chk("R8 no irq while stopped", bad_irq, 0);
        chk("R8 level held high while stopped", bad_lvl, 0);
        start_latency();
        chk("R9 irq latency after high stop", l_irq, 1025);

        // Stop while low
        repeat (150) @(negedge clk);
        chk("R3 output low late in section", int'(pwm_out), 0);
        run = 1'b0;
        bad_lvl = 0;
        repeat (100) begin
            @(negedge clk);
            if (pwm_out !== 1'b0) bad_lvl++;
        end
        chk("R8 level held low while stopped", bad_lvl, 0);
        start_latency();
        chk("R10 first high after low stop", l_hi, 257);
        chk("R10 irq latency after low stop", l_irq, 1281);

        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

endmodule